// File: doc/BRIEF.md
# Two-wire EEPROM slave protocol engine

This block is the bus-facing side of a small byte-addressed nonvolatile array reached over a two-wire serial bus. It samples the SCL and SDA lines with the system clock, cleans them with a synchronizer and a three-sample majority vote, and finds start and stop conditions and clock edges. It then receives the device select word and the word address, acknowledges on the ninth clock, and serves reads from a memory read port. Incoming write bytes go out on a memory write port to a separate page-write engine. That engine also receives a commit pulse when the write transaction ends.

The array size is set by `MEM_BYTES`. For arrays larger than 256 bytes, the low bits of the strap field in the device select word are not compared with the straps. They carry the top bits of the array address instead. While the page-write engine reports that an internal write cycle is running, the slave does not acknowledge its device select word, so a master can poll for completion. A single address counter serves all accesses. It holds the address after the last byte accessed. During reads it wraps over the whole array, and during writes it wraps inside one page.

Top module: `twi_eeprom_slave`

## Requirements
- R1: Both bus lines pass a two-flip-flop synchronizer and a three-sample majority vote, so a pulse of one system clock on SCL or SDA has no effect on the received data or on the acknowledges.
- R2: An SDA fall while SCL is high is a start, and an SDA rise while SCL is high is a stop. A start at any point, including inside a byte, abandons the current transfer and begins device select reception again. A partially received byte is never written.
- R3: Received bits are taken on the SCL rising edge, most significant bit first. The slave starts pulling SDA low only while SCL is low.
- R4: The device select word is selected when bits 7..4 are 1010. Bit 0 set to 1 means read and set to 0 means write. With the default 512-byte array, bits 3..2 must equal straps 2..1 and bit 1 becomes array address bit 8. For 128 or 256 bytes all three bits 3..1 are compared with straps 2..0, for 1024 bytes only bit 3 is compared, and for 2048 bytes none is compared. On a mismatch the slave does not acknowledge and ignores the bus until the next start.
- R5: Each byte that a selected slave receives (device select, word address, data) is acknowledged by holding `sda_pull_o` high during the ninth clock. It is released on the SCL fall that ends that clock. After reset `sda_pull_o`, `mem_we_o` and `wr_commit_o` are 0.
- R6: In a write, the byte after the device select word loads the address counter. Each later data byte is written once, at the counter address. The counter then advances inside its `PAGE_BYTES` page, so the last byte of a page is followed by the first byte of the same page. A stop that ends a transaction in which at least one data byte was written gives a one-cycle `wr_commit_o` pulse.
- R7: A read header without a preceding address returns the byte at the counter, which holds the last accessed address plus one and is kept between transactions.
- R8: A write header carrying a word address, followed by a repeated start and a read header, returns the byte at the loaded address.
- R9: While reading, a master acknowledge on the ninth clock makes the next byte follow. A master non-acknowledge or a stop ends the transfer with SDA released. The read address wraps from the last array byte to 0.
- R10: While `wr_busy_i` is high, the device select word is not acknowledged. Once it is low again, the same header is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain driver enable) |
| strap_i | input | 3 | Board strap levels for device select bits 3..1 |
| wr_busy_i | input | 1 | Page-write engine is in its internal write cycle |
| mem_rd_addr_o | output | log2(MEM_BYTES) | Read address (the address counter) |
| mem_rd_data_i | input | 8 | Read data, one clock after the address |
| mem_we_o | output | 1 | One-cycle write strobe for a received data byte |
| mem_wr_addr_o | output | log2(MEM_BYTES) | Address of the byte being written |
| mem_wr_data_o | output | 8 | Data byte being written |
| wr_commit_o | output | 1 | One-cycle pulse: the write transaction ended with a stop |

## Verification
The bench builds the block with a 512-byte array, 16-byte pages and straps 101. With these values one device select bit becomes address bit 8 while the other two are still compared, so the partial compare and the address extension are covered together. Short transfers reach both the page wrap at a 16-byte boundary and the array wrap from address 511 to 0. A bench model of the page-write engine holds `wr_busy_i` high after each commit, which lets acknowledge polling be seen failing and then succeeding.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } twi_state_e;
endpackage

// File: rtl/twi_line_filter.sv
// Synchronizer plus three-sample majority vote per bus line, with edge pulses.
module twi_line_filter #(
  parameter int LINES       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] sync_q;
    logic [2:0]             hist_q;
    logic                   lvl_q, rise_q, fall_q;
    logic                   maj;

    assign maj = (hist_q[0] & hist_q[1]) | (hist_q[1] & hist_q[2]) |
                 (hist_q[0] & hist_q[2]);

    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q <= '1;
        hist_q <= 3'b111;
        lvl_q  <= 1'b1;
        rise_q <= 1'b0;
        fall_q <= 1'b0;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i[g]};
        hist_q <= {hist_q[1:0], sync_q[SYNC_STAGES-1]};
        lvl_q  <= maj;
        rise_q <= maj & ~lvl_q;
        fall_q <= ~maj & lvl_q;
      end
    end

    assign lvl_o[g]  = lvl_q;
    assign rise_o[g] = rise_q;
    assign fall_o[g] = fall_q;
  end
endmodule

// File: rtl/twi_sel_decode.sv
// Device select decode; the density decides which strap bits become address bits.
module twi_sel_decode #(
  parameter int AW  = 9,
  parameter int UBW = 1
) (
  input  logic [7:0]     dev_i,
  input  logic [2:0]     strap_i,
  output logic           hit_o,
  output logic           is_read_o,
  output logic [UBW-1:0] page_o
);
  localparam int UB = (AW > 8) ? (AW - 8) : 0;
  localparam logic [2:0] CMP_MASK = 3'(3'b111 << UB);

  assign hit_o     = (dev_i[7:4] == 4'b1010) &&
                     (((dev_i[3:1] ^ strap_i) & CMP_MASK) == 3'b000);
  assign is_read_o = dev_i[0];

  if (UB > 0) begin : g_ext
    assign page_o = dev_i[UB:1];
  end else begin : g_noext
    assign page_o = '0;
  end
endmodule

// File: rtl/twi_addr_counter.sv
// Shared address counter: load, whole-array step (reads), in-page step (writes).
module twi_addr_counter #(
  parameter int AW  = 9,
  parameter int PBW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_seq_i,
  input  logic          step_page_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (load_i) begin
      addr_q <= load_val_i;
    end else if (step_page_i) begin
      addr_q <= {addr_q[AW-1:PBW], addr_q[PBW-1:0] + PBW'(1)};
    end else if (step_seq_i) begin
      addr_q <= addr_q + AW'(1);
    end
  end

  assign addr_o = addr_q;

  // R6: a write step never leaves the current page
  p_page_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (step_page_i && !load_i) |=> (addr_q[AW-1:PBW] == $past(addr_q[AW-1:PBW])));
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
  parameter int MEM_BYTES  = 512,
  parameter int PAGE_BYTES = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         scl_i,
  input  logic                         sda_i,
  output logic                         sda_pull_o,
  input  logic [2:0]                   strap_i,
  input  logic                         wr_busy_i,
  output logic [$clog2(MEM_BYTES)-1:0] mem_rd_addr_o,
  input  logic [7:0]                   mem_rd_data_i,
  output logic                         mem_we_o,
  output logic [$clog2(MEM_BYTES)-1:0] mem_wr_addr_o,
  output logic [7:0]                   mem_wr_data_o,
  output logic                         wr_commit_o
);
  import twi_pkg::*;

  localparam int AW  = $clog2(MEM_BYTES);
  localparam int PBW = $clog2(PAGE_BYTES);
  localparam int UBW = (AW > 8) ? (AW - 8) : 1;

  // ---- line conditioning: index 0 = SCL, index 1 = SDA ----
  logic [1:0] lvl, rise, fall;
  twi_line_filter #(.LINES(2), .SYNC_STAGES(2)) u_filt (
    .clk(clk), .rst(rst), .raw_i({sda_i, scl_i}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  assign scl_lvl   = lvl[0];
  assign sda_lvl   = lvl[1];
  assign scl_rise  = rise[0];
  assign scl_fall  = fall[0];
  assign start_det = fall[1] & scl_lvl;
  assign stop_det  = rise[1] & scl_lvl;

  // ---- state ----
  twi_state_e     state;
  logic [3:0]     bit_cnt;
  logic [7:0]     sh;
  logic [6:0]     tx;
  logic           rd_mode, mack_q, wrote_q;
  logic [UBW-1:0] page_q;

  // ---- device select decode ----
  logic           sel_hit, sel_read;
  logic [UBW-1:0] sel_page;
  twi_sel_decode #(.AW(AW), .UBW(UBW)) u_sel (
    .dev_i(sh), .strap_i(strap_i),
    .hit_o(sel_hit), .is_read_o(sel_read), .page_o(sel_page)
  );

  // ---- address counter ----
  logic          edge_ok, cnt_load, cnt_step_r, cnt_step_w;
  logic [AW-1:0] load_val, cnt_addr;

  if (AW > 8) begin : g_wide
    assign load_val = {page_q, sh};
  end else begin : g_narrow
    assign load_val = sh[AW-1:0];
  end

  always_comb begin
    edge_ok    = !start_det && !stop_det;
    cnt_load   = edge_ok && scl_fall && (bit_cnt == 4'd8) && (state == ST_ADDR);
    cnt_step_w = edge_ok && scl_fall && (bit_cnt == 4'd8) && (state == ST_WDATA);
    cnt_step_r = edge_ok && scl_fall && (bit_cnt == 4'd9) &&
                 (((state == ST_DEV) && rd_mode) || ((state == ST_RDATA) && mack_q));
  end

  twi_addr_counter #(.AW(AW), .PBW(PBW)) u_cnt (
    .clk(clk), .rst(rst), .load_i(cnt_load), .load_val_i(load_val),
    .step_seq_i(cnt_step_r), .step_page_i(cnt_step_w), .addr_o(cnt_addr)
  );
  assign mem_rd_addr_o = cnt_addr;

  // ---- protocol sequencer ----
  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      bit_cnt       <= '0;
      sh            <= '0;
      tx            <= '0;
      rd_mode       <= 1'b0;
      mack_q        <= 1'b0;
      wrote_q       <= 1'b0;
      page_q        <= '0;
      sda_pull_o    <= 1'b0;
      mem_we_o      <= 1'b0;
      mem_wr_addr_o <= '0;
      mem_wr_data_o <= '0;
      wr_commit_o   <= 1'b0;
    end else begin
      mem_we_o    <= 1'b0;
      wr_commit_o <= 1'b0;
      if (start_det) begin
        state      <= ST_DEV;
        bit_cnt    <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_det) begin
        state       <= ST_IDLE;
        bit_cnt     <= '0;
        sda_pull_o  <= 1'b0;
        wr_commit_o <= wrote_q;
        wrote_q     <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_DEV, ST_ADDR, ST_WDATA: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              sh      <= {sh[6:0], sda_lvl};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_rise && bit_cnt == 4'd8) begin
              bit_cnt <= 4'd9;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (state == ST_DEV) begin
                if (sel_hit && !wr_busy_i) begin
                  sda_pull_o <= 1'b1;
                  rd_mode    <= sel_read;
                  if (!sel_read) page_q <= sel_page;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_ADDR) begin
                sda_pull_o <= 1'b1;
              end else begin
                sda_pull_o    <= 1'b1;
                mem_we_o      <= 1'b1;
                mem_wr_addr_o <= cnt_addr;
                mem_wr_data_o <= sh;
                wrote_q       <= 1'b1;
              end
            end else if (scl_fall && bit_cnt == 4'd9) begin
              bit_cnt    <= '0;
              sda_pull_o <= 1'b0;
              if (state == ST_DEV) begin
                if (rd_mode) begin
                  state      <= ST_RDATA;
                  tx         <= mem_rd_data_i[6:0];
                  sda_pull_o <= ~mem_rd_data_i[7];
                end else begin
                  state <= ST_ADDR;
                end
              end else if (state == ST_ADDR) begin
                state <= ST_WDATA;
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_rise && bit_cnt == 4'd8) begin
              mack_q  <= ~sda_lvl;
              bit_cnt <= 4'd9;
            end else if (scl_fall && bit_cnt >= 4'd1 && bit_cnt <= 4'd7) begin
              sda_pull_o <= ~tx[6];
              tx         <= {tx[5:0], 1'b0};
            end else if (scl_fall && bit_cnt == 4'd8) begin
              sda_pull_o <= 1'b0;
            end else if (scl_fall && bit_cnt == 4'd9) begin
              bit_cnt <= '0;
              if (mack_q) begin
                tx         <= mem_rd_data_i[6:0];
                sda_pull_o <= ~mem_rd_data_i[7];
              end else begin
                state      <= ST_IDLE;
                sda_pull_o <= 1'b0;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // ---- assertions ----
  p_pull_scl_low_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_o) |-> !scl_lvl);

  p_idle_released_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_pull_o);

  p_busy_no_ack_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DEV && scl_fall && bit_cnt == 4'd8 && wr_busy_i && edge_ok)
      |=> !sda_pull_o);

  p_commit_on_stop_r6: assert property (@(posedge clk) disable iff (rst)
    wr_commit_o |-> $past(stop_det));

  p_write_acked_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> sda_pull_o);

  p_start_restarts_r2: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_DEV && bit_cnt == 4'd0 && !sda_pull_o));
endmodule

// File: tb/twi_eeprom_slave_tb.sv
`timescale 1ns/1ps
module twi_eeprom_slave_tb;
  localparam int MEM_BYTES  = 512;
  localparam int PAGE_BYTES = 16;
  localparam int AW         = $clog2(MEM_BYTES);
  localparam int Q          = 8;
  localparam int BUSY_LEN   = 1500;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          m_scl = 1'b1, m_sda = 1'b1;
  logic          sda_pull, mem_we, wr_commit;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0]    rd_data, wr_data;
  logic          busy;
  wire           sda_bus = m_sda & ~sda_pull;

  int   busy_cnt;
  int   commits;
  int   drive_viol;
  logic pull_prev;
  int   checks = 0, fails = 0;
  bit   done = 0;

  logic [7:0] mem [0:MEM_BYTES-1];

  twi_eeprom_slave #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_pull_o(sda_pull),
    .strap_i(3'b101), .wr_busy_i(busy), .mem_rd_addr_o(rd_addr),
    .mem_rd_data_i(rd_data), .mem_we_o(mem_we), .mem_wr_addr_o(wr_addr),
    .mem_wr_data_o(wr_data), .wr_commit_o(wr_commit)
  );

  function automatic logic [7:0] init_val(input int a);
    logic [8:0] v;
    v = 9'(a);
    return v[7:0] ^ 8'h5A ^ (v[8] ? 8'hFF : 8'h00);
  endfunction

  // memory and page-write engine model
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= init_val(i);
      busy_cnt <= 0;
      commits  <= 0;
    end else begin
      if (mem_we) mem[wr_addr] <= wr_data;
      if (wr_commit) begin
        busy_cnt <= BUSY_LEN;
        commits  <= commits + 1;
      end else if (busy_cnt != 0) begin
        busy_cnt <= busy_cnt - 1;
      end
    end
    rd_data <= mem[rd_addr];
  end
  assign busy = (busy_cnt != 0);

  // R3 monitor: pull may only begin while the raw clock line is low
  always @(posedge clk) begin
    if (rst) begin
      drive_viol <= 0;
      pull_prev  <= 1'b0;
    end else begin
      pull_prev <= sda_pull;
      if (sda_pull && !pull_prev && m_scl) drive_viol <= drive_viol + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_q(1);
    m_scl = 1'b1; wait_q(1);
    m_sda = 1'b0; wait_q(1);
    m_scl = 1'b0; wait_q(1);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_q(1);
    m_scl = 1'b1; wait_q(1);
    m_sda = 1'b1; wait_q(1);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; wait_q(1);
      if (glitch && i == 4) begin
        m_scl = 1'b1; @(negedge clk); m_scl = 1'b0; wait_q(1);
      end
      m_scl = 1'b1; wait_q(1);
      if (glitch && i == 7) begin
        m_sda = 1'b0; @(negedge clk); m_sda = 1'b1; wait_q(1);
      end
      wait_q(1);
      m_scl = 1'b0; wait_q(1);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
    send_bits(b, 8, glitch);
    m_sda = 1'b1; wait_q(1);
    m_scl = 1'b1; wait_q(1);
    acked = !sda_bus;
    wait_q(1);
    m_scl = 1'b0; wait_q(1);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_q(1); m_scl = 1'b1; wait_q(1);
      b[i] = sda_bus;
      wait_q(1); m_scl = 1'b0;
    end
    wait_q(1);
    m_sda = give_ack ? 1'b0 : 1'b1; wait_q(1);
    m_scl = 1'b1; wait_q(2);
    m_scl = 1'b0; wait_q(1);
  endtask

  task automatic wait_ready();
    while (busy) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R5 reset sda_pull", int'(sda_pull), 0);
    chk("R5 reset mem_we", int'(mem_we), 0);
    chk("R6 reset wr_commit", int'(wr_commit), 0);
  endtask

  task automatic t_mismatch();
    bit a;
    bus_start(); send_byte(8'hAC, 0, a);
    chk("R4 strap mismatch not acked", int'(a), 0);
    send_byte(8'hA8, 0, a);
    chk("R4 ignored until next start", int'(a), 0);
    bus_stop();
    bus_start(); send_byte(8'hB8, 0, a);
    chk("R4 wrong prefix not acked", int'(a), 0);
    bus_stop();
  endtask

  task automatic t_page_write();
    bit a;
    bus_start(); send_byte(8'hAA, 0, a); chk("R5 ack write header", int'(a), 1);
    send_byte(8'hFE, 0, a); chk("R5 ack word address", int'(a), 1);
    send_byte(8'h11, 0, a); chk("R5 ack data 0", int'(a), 1);
    send_byte(8'h22, 0, a); chk("R5 ack data 1", int'(a), 1);
    send_byte(8'h33, 0, a); chk("R5 ack data 2", int'(a), 1);
    bus_stop(); repeat (4) @(negedge clk);
    chk("R6 data at 0x1FE", int'(mem[9'h1FE]), 8'h11);
    chk("R6 data at 0x1FF", int'(mem[9'h1FF]), 8'h22);
    chk("R6 page wrap to 0x1F0", int'(mem[9'h1F0]), 8'h33);
    chk("R4 select bit gave address bit 8", int'(mem[9'h0FE]), int'(init_val(9'h0FE)));
    chk("R6 one commit", commits, 1);
  endtask

  task automatic t_busy_poll();
    bit a; logic [7:0] d;
    bus_start(); send_byte(8'hAB, 0, a);
    chk("R10 no ack while busy", int'(a), 0);
    bus_stop();
    wait_ready();
    bus_start(); send_byte(8'hAB, 0, a);
    chk("R10 ack after busy ends", int'(a), 1);
    recv_byte(0, d);
    chk("R7 current read after page write", int'(d), int'(init_val(9'h1F1)));
    bus_stop();
  endtask

  task automatic t_seq_read();
    bit a; logic [7:0] d;
    bus_start(); send_byte(8'hAA, 0, a); send_byte(8'hFE, 0, a);
    bus_start(); send_byte(8'hAB, 0, a);
    chk("R8 read header acked", int'(a), 1);
    recv_byte(1, d); chk("R8 random read 0x1FE", int'(d), 8'h11);
    recv_byte(1, d); chk("R9 sequential 0x1FF", int'(d), 8'h22);
    recv_byte(1, d); chk("R9 array wrap to 0", int'(d), int'(init_val(0)));
    recv_byte(0, d); chk("R9 sequential 0x001", int'(d), int'(init_val(1)));
    wait_q(2);
    chk("R9 released after nack", int'(sda_pull), 0);
    bus_stop();
    bus_start(); send_byte(8'hA9, 0, a);
    recv_byte(0, d);
    chk("R7 counter kept between transfers", int'(d), int'(init_val(2)));
    bus_stop();
  endtask

  task automatic t_abort();
    bit a; int c0;
    bus_start(); send_bits(8'hAA, 4, 0);
    bus_start(); send_byte(8'hA8, 0, a);
    chk("R2 header after mid-byte start acked", int'(a), 1);
    send_byte(8'h10, 0, a); send_byte(8'h99, 0, a);
    bus_stop(); repeat (4) @(negedge clk);
    chk("R2 write after abort", int'(mem[9'h010]), 8'h99);
    wait_ready();
    c0 = commits;
    bus_start(); send_byte(8'hA8, 0, a); send_byte(8'h20, 0, a);
    send_bits(8'h00, 5, 0);
    bus_start(); bus_stop(); repeat (4) @(negedge clk);
    chk("R2 partial byte not written", int'(mem[9'h020]), int'(init_val(9'h020)));
    chk("R6 no commit without a full byte", commits, c0);
  endtask

  task automatic t_glitch();
    bit a;
    bus_start(); send_byte(8'hA8, 0, a); send_byte(8'h30, 0, a);
    send_byte(8'hC3, 1, a);
    chk("R1 ack with glitches", int'(a), 1);
    bus_stop(); repeat (4) @(negedge clk);
    chk("R1 data with glitches", int'(mem[9'h030]), 8'hC3);
    wait_ready();
  endtask

  task automatic t_drive_edges();
    chk("R3 pull began only with clock low", drive_viol, 0);
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    t_reset();
    t_mismatch();
    t_page_write();
    t_busy_poll();
    t_seq_read();
    t_abort();
    t_glitch();
    t_drive_edges();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule